// File: doc/BRIEF.md
# Nibble-Programmed Synchronous Serial Port

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a data input and a data output. It can act as master, generating the shift clock, or as slave, following a clock from the other end. A 4-bit processor bus programs it through a handful of nibble-wide registers. These set the clock source, the clock format, the bit order, the role, the output enables and a handshake pin. The byte to send and the byte received share one 8-bit data register, which is split across two nibble addresses.

Software loads the data nibbles and chooses the mode, then writes the trigger bit in the control register. The same bit reads back as a busy flag until the eighth shift clock has completed. At that point the received byte has replaced the transmitted one. In master mode the shift clock comes from one of three sources:

- a divided tap of a fast oscillator tick;
- a divided tap of a slow oscillator tick;
- every second underflow of an external timer.

In slave mode the external clock is synchronised, and the block reacts to it only while an optional select input is low.

Top module: `sio_port`

## Requirements
- R1: After reset every register address reads 0. The shift clock output sits low, and every enable output (`sclk_oe`, `sdo_oe`, `hs_oe`, `port_en`) is 0.
- R2: The register map is as follows. Address 0 holds the clock select in bits 2:0. Address 1 holds the port enable in bit 0, the trigger/busy bit in bit 1 and the output enable in bit 2. Address 2 holds the role in bit 0 (1 = master), the bit order in bit 1 (1 = MSB first) and the clock format in bits 3:2. Address 3 holds the handshake enable in bit 0 and the handshake role in bit 1 (1 = ready output, 0 = select input). Address 4 holds data bits 3:0 and address 5 holds data bits 7:4. Unused bits and addresses 6–7 read 0.
- R3: A write to address 1 with bits 0 and 1 both set starts a transfer and bit 1 then reads 1. Writing 0 to bit 1 leaves a running transfer untouched. Clearing bit 0 aborts the transfer, and bit 1 then reads 0.
- R4: A transfer consists of exactly 16 shift-clock edges (8 clock periods). The busy bit clears on the last edge.
- R5: The clock format selects the idle level and the sampling edge. With format 0 the clock idles low and input is sampled on the rising edge. Format 1 idles low and samples on the falling edge. Format 2 idles high and samples on the falling edge. Format 3 idles high and samples on the rising edge. Output data changes on the other edge, and the first bit is already valid before the first edge.
- R6: With bit order 0, data bit 0 is sent and received first. With bit order 1, bit 7 goes first.
- R7: In master mode each clock event toggles the shift clock. Clock select 5, 6 and 7 produce an event on every 1st, 2nd and 4th fast tick. Select 1, 2 and 3 do the same with the slow tick. Select 4 produces an event on every second timer underflow. Select 0 produces no event.
- R8: In slave mode each edge of the synchronised `sclk_in` is a clock event. When the handshake is enabled with its select role, edges are ignored while `hs_in` is high.
- R9: Data-register writes are ignored while a transfer runs. At the end of the transfer the register holds the received byte.
- R10: `port_en` equals the port enable. `sclk_oe` is port enable AND master, and `sdo_oe` is port enable AND output enable. `hs_oe` is port enable AND handshake enable AND ready role. `hs_out` is high under the same conditions when no transfer is running.
- R11: A trigger written while the port enable is 0 does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Register read data (combinational) |
| fast_tick | input | 1 | Fast oscillator tick enable |
| slow_tick | input | 1 | Slow oscillator tick enable |
| tmr_uf | input | 1 | Timer underflow pulse |
| sclk_in | input | 1 | External shift clock (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | Shift clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| hs_in | input | 1 | Slave-select input, active low |
| hs_out | output | 1 | Ready output |
| hs_oe | output | 1 | Handshake pin output enable |
| port_en | output | 1 | Serial function pin enable |

## Verification
The hardest state to reach from the ports is a slave transfer that has been triggered but is held off by a high select input while the external clock keeps toggling. In that state the shifter must neither advance nor accept data writes.

The bench sets the handshake pin to its select role, triggers a slave transfer with `hs_in` high, and toggles `sclk_in` through several edges. It then checks that the busy bit is still set and that the data register reads back unchanged, including after an attempted write. Only after these checks does it lower the select input and clock all 16 edges. The same sweep covers every clock format and bit order in both roles.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

  typedef enum logic [1:0] {SRC_NONE, SRC_FAST, SRC_SLOW, SRC_TMR} clk_src_e;

  // layout of the mode register (address 2)
  typedef struct packed {
    logic [1:0] fmt;
    logic       msb_first;
    logic       master;
  } mode_t;

  function automatic clk_src_e src_of(input logic [2:0] sel);
    case (sel)
      3'd0:                src_of = SRC_NONE;
      3'd4:                src_of = SRC_TMR;
      3'd5, 3'd6, 3'd7:    src_of = SRC_FAST;
      default:             src_of = SRC_SLOW;
    endcase
  endfunction

  // terminal count of the tap prescaler: /4 -> 3, /2 -> 1, /1 -> 0
  function automatic logic [1:0] tap_limit(input logic [2:0] sel);
    case (sel[1:0])
      2'b11:   tap_limit = 2'd3;
      2'b10:   tap_limit = 2'd1;
      default: tap_limit = 2'd0;
    endcase
  endfunction

  function automatic logic idle_level(input logic [1:0] fmt);
    idle_level = fmt[1];
  endfunction

  function automatic logic lead_sample(input logic [1:0] fmt);
    lead_sample = ~fmt[0];
  endfunction

endpackage

// File: rtl/sio_clkgen.sv
`timescale 1ns/1ps
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       master,
  input  logic [2:0] clksel,
  input  logic       fast_tick,
  input  logic       slow_tick,
  input  logic       tmr_uf,
  input  logic       sclk_in,
  input  logic       ss_open,
  output logic       evt
);
  clk_src_e         src;
  logic [1:0]       pcnt;
  logic             tphase;
  logic [SYNC-1:0]  sync_q;
  logic             sprev;

  assign src = src_of(clksel);

  wire tap_tick = (src == SRC_FAST) ? fast_tick :
                  (src == SRC_SLOW) ? slow_tick : 1'b0;
  wire tap_evt  = run && tap_tick && (pcnt == tap_limit(clksel));
  wire tmr_evt  = run && (src == SRC_TMR) && tmr_uf && tphase;
  wire ext_edge = sync_q[SYNC-1] ^ sprev;
  wire slv_evt  = run && ext_edge && ss_open;

  assign evt = master ? (tap_evt || tmr_evt) : slv_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt   <= '0;
      tphase <= 1'b0;
      sync_q <= '0;
      sprev  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], sclk_in};
      sprev  <= sync_q[SYNC-1];
      if (restart) begin
        pcnt   <= '0;
        tphase <= 1'b0;
      end else if (run) begin
        if (tap_tick)
          pcnt <= (pcnt == tap_limit(clksel)) ? 2'd0 : pcnt + 2'd1;
        if (src == SRC_TMR && tmr_uf)
          tphase <= ~tphase;
      end
    end
  end
endmodule

// File: rtl/sio_shifter.sv
`timescale 1ns/1ps
module sio_shifter #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                load,
  input  logic                evt,
  input  logic                lead_smp,
  input  logic                msb_first,
  input  logic                sdi,
  input  logic [DW/NW-1:0]    nib_we,
  input  logic [NW-1:0]       nib_wdata,
  output logic [DW-1:0]       data,
  output logic                obit,
  output logic                last_evt
);
  localparam int NIB = DW / NW;
  localparam int CW  = $clog2(2 * DW);

  logic [CW-1:0] ecnt;

  function automatic logic head_bit(input logic [DW-1:0] v, input logic msb);
    head_bit = msb ? v[DW-1] : v[0];
  endfunction

  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] v, input logic b,
                                             input logic msb);
    push_bit = msb ? {v[DW-2:0], b} : {b, v[DW-1:1]};
  endfunction

  wire sample_now = ecnt[0] ^ lead_smp;
  assign last_evt = evt && (ecnt == CW'(2 * DW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      obit <= 1'b0;
      ecnt <= '0;
    end else if (load) begin
      ecnt <= '0;
      obit <= head_bit(data, msb_first);
    end else if (run) begin
      if (evt) begin
        ecnt <= ecnt + 1'b1;
        if (sample_now) data <= push_bit(data, sdi, msb_first);
        else            obit <= head_bit(data, msb_first);
      end
    end else begin
      for (int n = 0; n < NIB; n++)
        if (nib_we[n]) data[n*NW +: NW] <= nib_wdata;
    end
  end
endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
  import sio_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NW   = 4,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [NW-1:0] bus_wdata,
  output logic [NW-1:0] bus_rdata,
  input  logic          fast_tick,
  input  logic          slow_tick,
  input  logic          tmr_uf,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          sclk_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          hs_in,
  output logic          hs_out,
  output logic          hs_oe,
  output logic          port_en
);
  localparam int NIB = DW / NW;
  localparam logic [AW-1:0] A_CLK  = AW'(0);
  localparam logic [AW-1:0] A_CTL  = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_HS   = AW'(3);
  localparam int            A_DAT  = 4;

  logic [2:0]    clksel;
  logic          sif_en, dout_en, run, hs_en, hs_ready, sclk_q;
  mode_t         mode;
  logic [NIB-1:0] nib_we;
  logic [DW-1:0] shift_data;
  logic          shift_evt, last_evt, obit;

  wire wr_ctl   = bus_wr && (bus_addr == A_CTL);
  wire start    = wr_ctl && bus_wdata[0] && bus_wdata[1] && !run;
  wire ss_open  = !(hs_en && !hs_ready) || !hs_in;

  for (genvar n = 0; n < NIB; n++) begin : g_nwe
    assign nib_we[n] = bus_wr && (bus_addr == AW'(A_DAT + n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clksel   <= '0;
      sif_en   <= 1'b0;
      dout_en  <= 1'b0;
      mode     <= '0;
      hs_en    <= 1'b0;
      hs_ready <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CLK:  clksel <= bus_wdata[2:0];
        A_CTL:  begin sif_en <= bus_wdata[0]; dout_en <= bus_wdata[2]; end
        A_MODE: mode <= mode_t'(bus_wdata);
        A_HS:   begin hs_en <= bus_wdata[0]; hs_ready <= bus_wdata[1]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       run <= 1'b0;
    else if (wr_ctl && !bus_wdata[0]) run <= 1'b0;
    else if (start)                   run <= 1'b1;
    else if (last_evt)                run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      sclk_q <= 1'b0;
    else if (!run)                   sclk_q <= idle_level(mode.fmt);
    else if (shift_evt && mode.master) sclk_q <= ~sclk_q;
  end

  sio_clkgen #(.SYNC(SYNC)) i_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(start), .master(mode.master),
    .clksel(clksel), .fast_tick(fast_tick), .slow_tick(slow_tick), .tmr_uf(tmr_uf),
    .sclk_in(sclk_in), .ss_open(ss_open), .evt(shift_evt)
  );

  sio_shifter #(.DW(DW), .NW(NW)) i_shifter (
    .clk(clk), .rst_n(rst_n), .run(run), .load(start), .evt(shift_evt),
    .lead_smp(lead_sample(mode.fmt)), .msb_first(mode.msb_first), .sdi(sdi),
    .nib_we(nib_we), .nib_wdata(bus_wdata), .data(shift_data), .obit(obit),
    .last_evt(last_evt)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CLK:  bus_rdata = NW'(clksel);
      A_CTL:  bus_rdata = NW'({dout_en, run, sif_en});
      A_MODE: bus_rdata = NW'(mode);
      A_HS:   bus_rdata = NW'({hs_ready, hs_en});
      default: ;
    endcase
    for (int n = 0; n < NIB; n++)
      if (bus_addr == AW'(A_DAT + n)) bus_rdata = shift_data[n*NW +: NW];
  end

  assign sclk_out = sclk_q;
  assign sclk_oe  = sif_en && mode.master;
  assign sdo      = obit;
  assign sdo_oe   = sif_en && dout_en;
  assign hs_oe    = sif_en && hs_en && hs_ready;
  assign hs_out   = sif_en && hs_en && hs_ready && !run;
  assign port_en  = sif_en;
endmodule

// File: rtl/sio_chk.sv
`timescale 1ns/1ps
module sio_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          shift_evt,
  input logic          master,
  input logic [2:0]    clksel,
  input logic [1:0]    fmt,
  input logic          sclk_out,
  input logic          sdo,
  input logic [DW-1:0] shift_data,
  input logic          sif_en,
  input logic          hs_en,
  input logic          hs_ready,
  input logic          hs_in
);
  localparam int CW = $clog2(2 * DW) + 1;
  logic [CW-1:0] ev_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ev_cnt <= '0;
    else if (shift_evt) ev_cnt <= ev_cnt + 1'b1;
  end

  // R4: a transfer that ends without an abort has seen 2*DW edges
  p_edge_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && sif_en) |-> ev_cnt == CW'(2 * DW));

  // R5: between transfers the clock rests at the format's idle level
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run) && $stable(fmt)) |-> sclk_out == fmt[1]);

  // R6: output data changes only after a clock event
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !shift_evt) |=> $stable(sdo));

  // R7: clock select 0 in master mode never makes an event
  p_clk_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && master && clksel == 3'd0) |-> !shift_evt);

  // R8: a deselected slave makes no event
  p_ss_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !master && hs_en && !hs_ready && hs_in) |-> !shift_evt);

  // R9: data register frozen while running, except on clock events
  p_data_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !shift_evt) |=> $stable(shift_data));
endmodule

bind sio_port sio_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .shift_evt(shift_evt),
  .master(mode.master), .clksel(clksel), .fmt(mode.fmt), .sclk_out(sclk_out),
  .sdo(sdo), .shift_data(shift_data), .sif_en(sif_en), .hs_en(hs_en),
  .hs_ready(hs_ready), .hs_in(hs_in)
);

// File: tb/test_sio_port.sv
`timescale 1ns/1ps
module test_sio_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic fast_tick, slow_tick, tmr_uf;
  logic sclk_in = 1'b0, sclk_out, sclk_oe, sdi = 1'b0, sdo, sdo_oe;
  logic hs_in = 1'b1, hs_out, hs_oe, port_en;
  int   errors = 0, checks = 0;
  int   tc = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) tc <= tc + 1;
  assign fast_tick = 1'b1;
  assign slow_tick = (tc % 3) == 0;
  assign tmr_uf    = (tc % 5) == 0;

  sio_port i_sio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_en), .bus_wdata(wdata),
    .bus_rdata(rdata), .fast_tick(fast_tick), .slow_tick(slow_tick), .tmr_uf(tmr_uf),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .hs_in(hs_in), .hs_out(hs_out), .hs_oe(hs_oe), .port_en(port_en)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk); addr = a; #0.5; d = rdata;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    logic [3:0] lo, hi;
    rd(3'd4, lo); rd(3'd5, hi); b = {hi, lo};
  endtask

  function automatic logic pick(input logic [7:0] b, input int k, input logic msb);
    return msb ? b[7-k] : b[k];
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // bench plays the slave against the design in master mode
  task automatic run_master(input logic [1:0] fmt, input logic msb, input logic [2:0] sel,
                            input logic [7:0] tx, input logic [7:0] rx,
                            input bit chk_rate, input int per);
    logic [7:0] cap, got; logic prev, lead; int ei, cyc;
    cap = '0; lead = ~fmt[0]; ei = 0; cyc = 0;
    wr(3'd4, tx[3:0]); wr(3'd5, tx[7:4]); wr(3'd2, {fmt, msb, 1'b1}); wr(3'd0, {1'b0, sel});
    wr(3'd1, 4'b0101);
    @(negedge clk);
    chk("R5 idle level before", sclk_out, fmt[1]);
    sdi = lead ? pick(rx, 0, msb) : 1'b0;
    wr(3'd1, 4'b0111);
    addr = 3'd1; #0.5;
    chk("R3 busy after trigger", rdata[1], 1);
    prev = sclk_out;
    while (rdata[1] === 1'b1 && cyc < 4000) begin
      @(negedge clk); #0.5; cyc++;
      if (sclk_out !== prev) begin
        if (((ei % 2) == 0) == lead) begin
          if (msb) cap[7 - ei/2] = sdo; else cap[ei/2] = sdo;
        end else begin
          sdi = pick(rx, lead ? (ei + 1) / 2 : ei / 2, msb);
        end
        ei++; prev = sclk_out;
      end
    end
    chk("R4 edges per transfer", ei, 16);
    chk("R6 R5 bits sent", cap, tx);
    @(negedge clk);
    chk("R5 idle level after", sclk_out, fmt[1]);
    rd_byte(got);
    chk("R9 received byte", got, rx);
    if (chk_rate) begin
      checks++;
      if (cyc < 16 * per - per - 2 || cyc > 16 * per + per + 2) begin
        errors++;
        $display("FAIL R7 sel=%0d: got %0d cycles expected about %0d", sel, cyc, 16 * per);
      end
    end
  endtask

  // bench plays the master against the design in slave mode
  task automatic run_slave(input logic [1:0] fmt, input logic msb, input logic [7:0] tx,
                           input logic [7:0] rx, input bit gate);
    logic [7:0] cap, got; logic lead; logic [3:0] r;
    cap = '0; lead = ~fmt[0];
    wr(3'd0, 4'd0); wr(3'd4, tx[3:0]); wr(3'd5, tx[7:4]); wr(3'd2, {fmt, msb, 1'b0});
    wr(3'd3, gate ? 4'b0001 : 4'b0000);
    hs_in = gate; sclk_in = fmt[1];
    wr(3'd1, 4'b0101);
    repeat (4) @(negedge clk);
    sdi = lead ? pick(rx, 0, msb) : 1'b0;
    wr(3'd1, 4'b0111);
    if (gate) begin
      for (int g = 0; g < 4; g++) begin repeat (8) @(negedge clk); sclk_in = ~sclk_in; end
      repeat (8) @(negedge clk);
      rd(3'd1, r);
      chk("R8 deselected slave still busy", r[1], 1);
      rd_byte(got);
      chk("R8 deselected slave did not shift", got, tx);
      wr(3'd4, ~tx[3:0]);
      rd(3'd4, r);
      chk("R9 data write ignored while busy", r, tx[3:0]);
      hs_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    for (int ei = 0; ei < 16; ei++) begin
      repeat (8) @(negedge clk);
      if (((ei % 2) == 0) == lead) begin
        if (msb) cap[7 - ei/2] = sdo; else cap[ei/2] = sdo;
        sclk_in = ~sclk_in;
      end else begin
        sclk_in = ~sclk_in;
        sdi = pick(rx, lead ? (ei + 1) / 2 : ei / 2, msb);
      end
    end
    repeat (8) @(negedge clk);
    rd(3'd1, r);
    chk("R4 R8 slave busy clears", r[1], 0);
    chk("R8 R6 slave bits sent", cap, tx);
    rd_byte(got);
    chk("R8 R9 slave received byte", got, rx);
    hs_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [3:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), r); chk("R1 reset read", r, 0); end
    chk("R1 sclk_out", sclk_out, 0);
    chk("R1 enables", {sclk_oe, sdo_oe, hs_oe, port_en}, 0);
    // R2 register map
    wr(3'd0, 4'hF); rd(3'd0, r); chk("R2 clock select", r, 4'h7);
    wr(3'd1, 4'b1101); rd(3'd1, r); chk("R2 control", r, 4'b0101);
    wr(3'd1, 4'b0000);
    wr(3'd2, 4'hF); rd(3'd2, r); chk("R2 mode", r, 4'hF);
    wr(3'd3, 4'hF); rd(3'd3, r); chk("R2 handshake", r, 4'h3);
    wr(3'd4, 4'hA); rd(3'd4, r); chk("R2 data low", r, 4'hA);
    wr(3'd5, 4'h5); rd(3'd5, r); chk("R2 data high", r, 4'h5);
    rd(3'd6, r); chk("R2 unused address 6", r, 0);
    rd(3'd7, r); chk("R2 unused address 7", r, 0);
    // R11 trigger with port disabled
    wr(3'd1, 4'b0010); rd(3'd1, r); chk("R11 no start when disabled", r, 0);
    // R10 enables and ready pin
    wr(3'd0, 4'd0); wr(3'd2, 4'b0001); wr(3'd3, 4'b0011); wr(3'd1, 4'b0101);
    @(negedge clk);
    chk("R10 outputs idle", {port_en, sclk_oe, sdo_oe, hs_oe, hs_out}, 5'b11111);
    // R7 clock off + R3 write-0 no effect + abort
    wr(3'd1, 4'b0111);
    @(negedge clk);
    chk("R10 ready drops while busy", hs_out, 0);
    repeat (100) @(negedge clk);
    chk("R7 select 0 makes no clock", sclk_out, 0);
    wr(3'd1, 4'b0101); rd(3'd1, r); chk("R3 writing 0 keeps busy", r[1], 1);
    wr(3'd1, 4'b0000); rd(3'd1, r); chk("R3 abort clears busy", r[1], 0);
    chk("R10 outputs off", {port_en, sclk_oe, sdo_oe, hs_oe}, 0);
    wr(3'd3, 4'b0000);
    // R5 R6 sweep, master
    for (int i = 0; i < 8; i++)
      run_master(2'(i % 4), 1'(i / 4), 3'd5, 8'hA5 ^ 8'(i * 37), 8'h3C + 8'(i * 53), 1'b0, 1);
    // R7 clock rates
    run_master(2'd0, 1'b0, 3'd6, 8'h81, 8'h7E, 1'b1, 2);
    run_master(2'd0, 1'b0, 3'd7, 8'h0F, 8'hF0, 1'b1, 4);
    run_master(2'd1, 1'b1, 3'd1, 8'h66, 8'h99, 1'b1, 3);
    run_master(2'd2, 1'b0, 3'd2, 8'h12, 8'hED, 1'b1, 6);
    run_master(2'd3, 1'b1, 3'd3, 8'hC3, 8'h5A, 1'b1, 12);
    run_master(2'd0, 1'b1, 3'd4, 8'h47, 8'hB8, 1'b1, 10);
    // R8 slave, gated run then sweep
    run_slave(2'd0, 1'b0, 8'h96, 8'h2B, 1'b1);
    for (int i = 0; i < 8; i++)
      run_slave(2'(i % 4), 1'(i / 4), 8'h5C ^ 8'(i * 29), 8'hE1 - 8'(i * 41), 1'b0);
    report();
  end
endmodule